// File: doc/BRIEF.md
# Trace Ring Buffer with Dual Register Readout

The block keeps a rolling history of a wide trace sample. On every clock edge when capture is enabled it stores the sample as one entry of an on-chip circular buffer and moves its write pointer on by one entry, wrapping at the end. Once the buffer fills, the oldest history is overwritten, so the buffer always holds the most recent `DEPTH` entries.

Software reads the history through two small register views, one on a processor register port and one on a debug port. Each view has an address/control register and a data register. The address/control register reports the current write position and the buffer size, and it holds that port's own read pointer and freeze bit. The data register returns one 64-bit doubleword per read and steps the read pointer. Capture stops while either port's freeze bit is set, so the buffer contents stay still during a readout. A depth of zero builds the register views with no storage behind them.

Top module: `trc_ring`

## Requirements
- R1: While neither freeze bit is set, every rising clock edge stores `sample_i` as the entry at the write pointer and advances the write pointer by one, wrapping from `DEPTH-1` to 0 (`DEPTH` a power of two).
- R2: A read of the address/control register (`sel`=0) returns the value `DEPTH | wp` in bits 63:32, where `wp` is the write pointer counted in entries. Software recovers the size as 1 << (31 - leading_zeros(bits 63:32)).
- R3: In that same read, bit 31 is the freeze bit of the reading port, and bits 30:0 hold that port's read pointer, counted in 64-bit doublewords.
- R4: A read of the data register (`sel`=1) returns doubleword `rp % (ENTRY_W/64)` of entry `rp / (ENTRY_W/64)`, where doubleword k occupies sample bits 64k+63 down to 64k. The read then adds one to the read pointer.
- R5: The read pointer wraps modulo `DEPTH*ENTRY_W/64` doublewords.
- R6: A write to the address/control register loads the read pointer from the low log2(`DEPTH*ENTRY_W/64`) bits of `wdata`, ignores the other low bits, and loads the freeze bit from `wdata[31]`. It never changes the write pointer.
- R7: Capture is halted while the freeze bit of either port is set. A freeze write on edge t still lets edge t capture, and edges from t+1 on do not. A clearing write on edge u lets capture resume from edge u+1.
- R8: A write to the data register has no effect on the read pointer, the freeze bit or the write pointer.
- R9: A read sampled on edge t puts its result on `rdata` and raises `rvalid` on edge t+1. `rvalid` is low in every other cycle, and `rdata` holds its last value.
- R10: The two ports keep separate read pointers and freeze bits, and an access on one port leaves the other port's pointer unchanged.
- R11: With `DEPTH` = 0 there is no storage and no capture. Data reads return zero, and bits 63:32 of the address/control register read as zero.
- R12: After reset both read pointers, both freeze bits, the write pointer, `rvalid` and `rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | ENTRY_W | Trace sample taken each enabled cycle |
| cpu_req | input | 1 | Processor port access strobe |
| cpu_we | input | 1 | Processor port write (1) or read (0) |
| cpu_sel | input | 1 | Processor port register: 0 address/control, 1 data |
| cpu_wdata | input | 64 | Processor port write data |
| cpu_rdata | output | 64 | Processor port read result |
| cpu_rvalid | output | 1 | Processor port read result valid |
| dbg_req | input | 1 | Debug port access strobe |
| dbg_we | input | 1 | Debug port write (1) or read (0) |
| dbg_sel | input | 1 | Debug port register: 0 address/control, 1 data |
| dbg_wdata | input | 64 | Debug port write data |
| dbg_rdata | output | 64 | Debug port read result |
| dbg_rvalid | output | 1 | Debug port read result valid |

## Verification
Every read result arrives one edge after the edge that samples the request: the storage read registers on the sampling edge and the output register loads on the next one. The bench drives each access at a falling edge and releases it at the next falling edge, where it confirms that `rvalid` is still low. It samples the result at the falling edge after that. A freeze change written on edge t first affects capture at edge t+1, so the gap tests derive the expected advance of the write pointer as the number of edges from the unfreeze edge up to and including the refreeze edge. Buffer contents are judged by the continuity of a per-cycle tag that the bench embeds in each sample, and never by the design's internal state.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int DWORD_W = 64;
  localparam int HALF_W  = 32;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_DATA = 1'b1
  } trc_reg_e;
endpackage

// File: rtl/trc_store.sv
module trc_store #(
  parameter int WIDTH = 256,
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/trc_wptr.sv
module trc_wptr #(
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frz_a,
  input  logic          frz_b,
  output logic          cap_en,
  output logic [AW-1:0] wp
);
  generate
    if (DEPTH > 0) begin : g_live
      assign cap_en = !(frz_a || frz_b);

      always_ff @(posedge clk) begin
        if (rst)         wp <= '0;
        else if (cap_en) wp <= wp + 1'b1;
      end

      // R7: a halted cycle leaves the write position untouched
      assert_wp_held_R7: assert property (@(posedge clk) disable iff (rst)
        (frz_a || frz_b) |=> $stable(wp));
      // R1: the last slot is followed by slot zero
      assert_wp_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (cap_en && wp == AW'(DEPTH - 1)) |=> (wp == '0));
    end else begin : g_none
      assign cap_en = 1'b0;
      assign wp     = '0;
      wire unused_frz = frz_a ^ frz_b ^ clk ^ rst;
    end
  endgenerate
endmodule

// File: rtl/trc_port.sv
module trc_port import trc_pkg::*; #(
  parameter int ENTRY_W = 256,
  parameter int DEPTH   = 2048,
  parameter int AW      = 11,
  parameter int LW      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic               we,
  input  logic               sel,
  input  logic [63:0]        wdata,
  input  logic               cap_en,
  input  logic [AW-1:0]      wp,
  input  logic [ENTRY_W-1:0] sample,
  output logic               frz,
  output logic [63:0]        rdata,
  output logic               rvalid
);
  localparam int RPW = AW + LW;

  logic [RPW-1:0]     rp;
  logic               frz_q;
  logic               rd_data, rd_ctrl, wr_ctrl, wr_data;
  logic [ENTRY_W-1:0] ent_q;
  logic               s1_v, s1_data;
  logic [LW-1:0]      s1_lane;
  logic [63:0]        s1_ctrl;
  logic [HALF_W-1:0]  hi_field;
  logic [63:0]        lane_word;

  assign rd_data = req && !we && (sel == REG_DATA);
  assign rd_ctrl = req && !we && (sel == REG_CTRL);
  assign wr_ctrl = req &&  we && (sel == REG_CTRL);
  assign wr_data = req &&  we && (sel == REG_DATA);
  assign frz     = frz_q;

  wire unused_wdata = ^wdata;

  assign hi_field = (DEPTH > 0) ? (HALF_W'(DEPTH) | HALF_W'(wp)) : '0;

  // pointer and freeze state
  always_ff @(posedge clk) begin
    if (rst) begin
      rp    <= '0;
      frz_q <= 1'b0;
    end else if (wr_ctrl) begin
      rp    <= wdata[RPW-1:0];
      frz_q <= wdata[31];
    end else if (rd_data) begin
      rp    <= rp + 1'b1;
    end
  end

  // storage copy owned by this port
  generate
    if (DEPTH > 0) begin : g_mem
      trc_store #(.WIDTH(ENTRY_W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (cap_en),
        .waddr (wp),
        .wdata (sample),
        .re    (rd_data),
        .raddr (rp[RPW-1:LW]),
        .rdata (ent_q)
      );
    end else begin : g_nomem
      assign ent_q = '0;
      wire unused_store = cap_en ^ (^sample);
    end
  endgenerate

  // first stage: remember what was asked
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_data <= 1'b0;
      s1_lane <= '0;
      s1_ctrl <= '0;
    end else begin
      s1_v    <= rd_data || rd_ctrl;
      s1_data <= rd_data;
      s1_lane <= rp[LW-1:0];
      s1_ctrl <= {hi_field, frz_q, 31'(rp)};
    end
  end

  assign lane_word = ent_q[s1_lane*DWORD_W +: DWORD_W];

  // second stage: registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= s1_v;
      if (s1_v) rdata <= s1_data ? lane_word : s1_ctrl;
    end
  end

  // R5: the last doubleword is followed by doubleword zero
  assert_rp_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_data && rp == {RPW{1'b1}}) |=> (rp == '0));
  // R8: data-register writes leave the port state alone
  assert_data_wr_inert_R8: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> ($stable(rp) && $stable(frz_q)));
  // R6: freeze bit follows bit 31 of a control write
  assert_frz_load_R6: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (frz_q == $past(wdata[31])));
  // R9: a result is presented exactly one edge after the first stage
  assert_result_due_R9: assert property (@(posedge clk) disable iff (rst)
    s1_v |=> rvalid);
  assert_no_stray_R9: assert property (@(posedge clk) disable iff (rst)
    !s1_v |=> !rvalid);
endmodule

// File: rtl/trc_ring.sv
module trc_ring import trc_pkg::*; #(
  parameter int ENTRY_W = 256,
  parameter int DEPTH   = 2048
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRY_W-1:0] sample_i,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic               cpu_sel,
  input  logic [63:0]        cpu_wdata,
  output logic [63:0]        cpu_rdata,
  output logic               cpu_rvalid,
  input  logic               dbg_req,
  input  logic               dbg_we,
  input  logic               dbg_sel,
  input  logic [63:0]        dbg_wdata,
  output logic [63:0]        dbg_rdata,
  output logic               dbg_rvalid
);
  localparam int LANES = ENTRY_W / DWORD_W;
  localparam int LW    = $clog2(LANES);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          frz_cpu, frz_dbg, cap_en;
  logic [AW-1:0] wp;

  trc_wptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
    .clk    (clk),
    .rst    (rst),
    .frz_a  (frz_cpu),
    .frz_b  (frz_dbg),
    .cap_en (cap_en),
    .wp     (wp)
  );

  trc_port #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH), .AW(AW), .LW(LW)) u_cpu (
    .clk    (clk),
    .rst    (rst),
    .req    (cpu_req),
    .we     (cpu_we),
    .sel    (cpu_sel),
    .wdata  (cpu_wdata),
    .cap_en (cap_en),
    .wp     (wp),
    .sample (sample_i),
    .frz    (frz_cpu),
    .rdata  (cpu_rdata),
    .rvalid (cpu_rvalid)
  );

  trc_port #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH), .AW(AW), .LW(LW)) u_dbg (
    .clk    (clk),
    .rst    (rst),
    .req    (dbg_req),
    .we     (dbg_we),
    .sel    (dbg_sel),
    .wdata  (dbg_wdata),
    .cap_en (cap_en),
    .wp     (wp),
    .sample (sample_i),
    .frz    (frz_dbg),
    .rdata  (dbg_rdata),
    .rvalid (dbg_rvalid)
  );

  // R11: without storage the write-position field stays zero
  assert_empty_field_R11: assert property (@(posedge clk) disable iff (rst)
    (DEPTH == 0 && cpu_rvalid) |-> (cpu_rdata[63:32] == '0));
endmodule

// File: tb/trc_ring_bench.sv
`timescale 1ns/1ps
module trc_ring_bench;
  localparam int ENTRY_W = 256;
  localparam int DEPTH   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] tag = '0;
  always @(posedge clk) tag <= tag + 1;

  logic [ENTRY_W-1:0] sample;
  always_comb
    for (int k = 0; k < 4; k++) sample[64*k +: 64] = {tag, 32'(k)};

  logic        cpu_req = 0, cpu_we = 0, cpu_sel = 0;
  logic        dbg_req = 0, dbg_we = 0, dbg_sel = 0;
  logic [63:0] cpu_wdata = '0, dbg_wdata = '0;
  logic [63:0] cpu_rdata, dbg_rdata, z_cpu_rdata, z_dbg_rdata;
  logic        cpu_rvalid, dbg_rvalid, z_cpu_rvalid, z_dbg_rvalid;

  trc_ring #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_trc_ring (
    .clk(clk), .rst(rst), .sample_i(sample),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_sel(dbg_sel), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata), .dbg_rvalid(dbg_rvalid));

  trc_ring #(.ENTRY_W(ENTRY_W), .DEPTH(0)) u_trc_ring_z (
    .clk(clk), .rst(rst), .sample_i(sample),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .cpu_rdata(z_cpu_rdata), .cpu_rvalid(z_cpu_rvalid),
    .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_sel(dbg_sel), .dbg_wdata(dbg_wdata),
    .dbg_rdata(z_dbg_rdata), .dbg_rvalid(z_dbg_rvalid));

  int n_chk = 0, n_bad = 0;
  logic [63:0] zv;
  logic [31:0] ent_tag [DEPTH];
  logic [31:0] w1;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // caller stands at a falling edge
  task automatic wr(input bit dbg, input bit sel, input logic [63:0] d);
    if (dbg) begin dbg_req = 1; dbg_we = 1; dbg_sel = sel; dbg_wdata = d; end
    else     begin cpu_req = 1; cpu_we = 1; cpu_sel = sel; cpu_wdata = d; end
    @(negedge clk);
    cpu_req = 0; cpu_we = 0; dbg_req = 0; dbg_we = 0;
  endtask

  task automatic rd(input bit dbg, input bit sel, output logic [63:0] v);
    if (dbg) begin dbg_req = 1; dbg_we = 0; dbg_sel = sel; end
    else     begin cpu_req = 1; cpu_we = 0; cpu_sel = sel; end
    @(negedge clk);
    cpu_req = 0; dbg_req = 0;
    chk((dbg ? dbg_rvalid : cpu_rvalid) == 1'b0, "R9 early rvalid", 64'(dbg ? dbg_rvalid : cpu_rvalid), 64'd0);
    @(negedge clk);
    chk((dbg ? dbg_rvalid : cpu_rvalid) == 1'b1, "R9 rvalid due", 64'(dbg ? dbg_rvalid : cpu_rvalid), 64'd1);
    v  = dbg ? dbg_rdata : cpu_rdata;
    zv = dbg ? z_dbg_rdata : z_cpu_rdata;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    chk(cpu_rvalid == 0 && dbg_rvalid == 0, "R12 rvalid at reset", 64'({cpu_rvalid, dbg_rvalid}), 64'd0);
    chk(cpu_rdata == 0 && dbg_rdata == 0, "R12 rdata at reset", cpu_rdata | dbg_rdata, 64'd0);
    rd(0, 0, v);
    chk(v[31:0] == 32'd0, "R12 cpu pointer/freeze", 64'(v[31:0]), 64'd0);
    rd(1, 0, v);
    chk(v[31:0] == 32'd0, "R12 dbg pointer/freeze", 64'(v[31:0]), 64'd0);
  endtask

  task automatic t_freeze_dump();
    logic [63:0] c1, c2, v;
    int msb;
    wr(0, 0, 64'h8000_0000);
    rd(0, 0, c1);
    repeat (5) @(negedge clk);
    rd(0, 0, c2);
    chk(c1[63:32] == c2[63:32], "R7 frozen write pointer", c2, c1);
    chk(c1[31] == 1'b1, "R3 freeze bit reported", 64'(c1[31]), 64'd1);
    msb = -1;
    for (int b = 0; b < 32; b++) if (c1[32+b]) msb = b;
    chk((1 << msb) == DEPTH, "R2 length from field", 64'(1 << msb), 64'(DEPTH));
    chk(c1[63:32] >= 32'(DEPTH) && c1[63:32] < 32'(2*DEPTH), "R2 field range", 64'(c1[63:32]), 64'(DEPTH));
    w1 = c1[63:32] & 32'(DEPTH - 1);
    for (int e = 0; e < DEPTH; e++)
      for (int k = 0; k < 4; k++) begin
        rd(0, 1, v);
        chk(v[31:0] == 32'(k), "R4 doubleword lane", 64'(v[31:0]), 64'(k));
        if (k == 0) ent_tag[e] = v[63:32];
        else chk(v[63:32] == ent_tag[e], "R4 lanes of one entry", 64'(v[63:32]), 64'(ent_tag[e]));
      end
    for (int i = 1; i < DEPTH; i++)
      chk(ent_tag[(w1 + i) % DEPTH] == ent_tag[w1] + 32'(i), "R1 consecutive capture",
          64'(ent_tag[(w1 + i) % DEPTH]), 64'(ent_tag[w1] + 32'(i)));
    rd(0, 0, v);
    chk(v[31:0] == 32'h8000_0000, "R5 pointer back at zero", 64'(v[31:0]), 64'h8000_0000);
  endtask

  task automatic t_wrap_mask_inert();
    logic [63:0] v;
    wr(0, 0, 64'h8000_0000 | 64'd63);
    rd(0, 1, v);
    chk(v == {ent_tag[DEPTH-1], 32'd3}, "R5 last doubleword", v, {ent_tag[DEPTH-1], 32'd3});
    rd(0, 1, v);
    chk(v == {ent_tag[0], 32'd0}, "R5 wraps to first", v, {ent_tag[0], 32'd0});
    rd(0, 0, v);
    chk(v[31:0] == 32'h8000_0001, "R5 pointer after wrap", 64'(v[31:0]), 64'h8000_0001);
    wr(0, 0, 64'hFFFF_0000_FFFF_FFC5);
    rd(0, 0, v);
    chk(v[31:0] == 32'h8000_0005, "R6 masked pointer load", 64'(v[31:0]), 64'h8000_0005);
    chk((v[63:32] & 32'(DEPTH - 1)) == w1, "R6 write pointer kept", 64'(v[63:32]), 64'(w1));
    wr(0, 1, '1);
    rd(0, 0, v);
    chk(v[31:0] == 32'h8000_0005, "R8 data write ignored", 64'(v[31:0]), 64'h8000_0005);
    chk((v[63:32] & 32'(DEPTH - 1)) == w1, "R8 write pointer kept", 64'(v[63:32]), 64'(w1));
  endtask

  task automatic t_two_ports();
    logic [63:0] v;
    wr(1, 0, 64'd9);
    rd(0, 1, v);
    chk(v == {ent_tag[1], 32'd1}, "R10 cpu read", v, {ent_tag[1], 32'd1});
    rd(1, 1, v);
    chk(v == {ent_tag[2], 32'd1}, "R10 dbg read", v, {ent_tag[2], 32'd1});
    chk(zv == 64'd0, "R11 empty data read", zv, 64'd0);
    rd(0, 0, v);
    chk(v[31:0] == 32'h8000_0006, "R10 cpu pointer", 64'(v[31:0]), 64'h8000_0006);
    rd(1, 0, v);
    chk(v[31:0] == 32'h0000_000A, "R10 dbg pointer", 64'(v[31:0]), 64'h0000_000A);
    chk(zv[63:32] == 32'd0, "R11 empty length field", zv, 64'd0);
  endtask

  task automatic t_gap();
    logic [63:0] v;
    logic [31:0] a, b;
    rd(0, 0, v); a = v[63:32] & 32'(DEPTH - 1);
    wr(0, 0, 64'd0);
    repeat (3) @(negedge clk);
    wr(0, 0, 64'h8000_0000);
    rd(0, 0, v); b = v[63:32] & 32'(DEPTH - 1);
    chk(b == ((a + 4) % DEPTH), "R7 captures across gap", 64'(b), 64'((a + 4) % DEPTH));
    wr(1, 0, 64'h8000_0000);
    wr(0, 0, 64'd0);
    rd(0, 0, v); a = v[63:32];
    repeat (4) @(negedge clk);
    rd(0, 0, v);
    chk(v[63:32] == a, "R7 debug freeze alone", 64'(v[63:32]), 64'(a));
    a = a & 32'(DEPTH - 1);
    wr(1, 0, 64'd0);
    @(negedge clk);
    wr(0, 0, 64'h8000_0000);
    rd(0, 0, v); b = v[63:32] & 32'(DEPTH - 1);
    chk(b == ((a + 2) % DEPTH), "R7 resume after clear", 64'(b), 64'((a + 2) % DEPTH));
    @(negedge clk);
    chk(cpu_rvalid == 0 && dbg_rvalid == 0, "R9 idle rvalid", 64'({cpu_rvalid, dbg_rvalid}), 64'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset_pre();
    rst = 0;
    repeat (DEPTH + 4) @(negedge clk);
    t_reset();
    t_freeze_dump();
    t_wrap_mask_inert();
    t_two_ports();
    t_gap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic t_reset_pre();
    chk(cpu_rvalid == 0 && dbg_rvalid == 0, "R12 outputs held in reset", 64'({cpu_rvalid, dbg_rvalid}), 64'd0);
  endtask
endmodule